// File: doc/BRIEF.md
# Compare-Match Interval Timer with Software Capture

This block is a 16-bit interval timer for a microcontroller peripheral. A free-running prescaler produces single-cycle enable pulses at one of several rates, and the count register advances by one on each pulse while the timer runs. When the incremented count equals a programmable compare value, the block emits a one-cycle interrupt request and restarts its count from zero. The timer then runs again with the same period.

Software uses a small register bus. The control byte is write-only. It carries the run bit, the rate selection, a low-speed substitution bit and a capture command. The capture command does not stay set: it copies the live count into a capture register once, and the bus reads that register back. Everything runs on one clock. The low-speed source enters as an enable pulse, `ls_tick`, that is already in the `clk` domain.

Top module: `cmp_timer`

## Requirements
- R1: After reset the timer is stopped, `irq` is 0 and `cap_rdata` reads 0.
- R2: While running, the count rises by one on each pulse of the selected source. Control bits [1:0] select the source: 0 gives the slowest tap (clk/2^HI_SH), 1 gives clk/2^MID_SH, and 2 or 3 give clk/2^LO_SH. Control writes go to address 0 and use bus_wdata[7:0].
- R3: When the incremented count equals the compare value, the count goes to 0 and `irq` is high for exactly one cycle. With compare value N ≥ 1, the interrupts are N source pulses apart.
- R4: A compare value of 0 produces an interrupt after 65536 source pulses.
- R5: Writing control bit 6 = 1 copies the current count into the capture register. The bit is not stored, so a later control write with bit 6 = 0 leaves the capture register unchanged.
- R6: If a capture lands on the same edge as a compare clear, the capture register receives the count as it was before the clear.
- R7: Bit 4 is the run bit. A 0→1 change clears the count and the prescaler and starts counting. A write of 0 stops the timer, and the count then holds. A write with bit 4 = 1 while the timer is already running does not restart it.
- R8: A write to the compare register (address 1, bus_wdata[15:0]) takes effect at once and leaves the count untouched.
- R9: When control bit 5 is 1, the slowest tap is replaced by one pulse for every 2^LS_SH pulses of `ls_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 compare |
| bus_wdata | input | 16 | Write data |
| ls_tick | input | 1 | Low-speed clock as a single-cycle enable pulse |
| cap_rdata | output | 16 | Capture register contents |
| irq | output | 1 | One-cycle interrupt request on compare match |

## Verification
Two situations are the hardest to reach from the ports. The first is a capture command that lands on exactly the edge where the compare clear happens. The bench reaches it by timing the control write against its own cycle counter, which it computes from the start edge and the tap period. The second is the 65536-pulse wrap with a compare value of 0. The bench instantiates the block with a two-cycle fast tap so that a full wrap fits within the run, and it treats any interrupt that comes early as a failure.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  parameter int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    SRC_SLOW  = 2'd0,
    SRC_MID   = 2'd1,
    SRC_FAST  = 2'd2,
    SRC_FAST2 = 2'd3
  } src_sel_e;

  // Bit positions inside the write-only control byte
  localparam int unsigned CB_SEL_LO = 0;
  localparam int unsigned CB_RUN    = 4;
  localparam int unsigned CB_LSPD   = 5;
  localparam int unsigned CB_CAP    = 6;

  // Next value of the counter on an enable pulse
  function automatic cnt_t step_count(cnt_t cur);
    return cur + cnt_t'(1);
  endfunction

  // A match happens when the incremented count reaches the compare value
  function automatic logic hits_compare(cnt_t cur, cnt_t cmp);
    return step_count(cur) == cmp;
  endfunction
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int unsigned HI_SH  = 11,
  parameter int unsigned MID_SH = 7,
  parameter int unsigned LO_SH  = 3,
  parameter int unsigned LS_SH  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       lspd_i,
  input  logic       ls_tick_i,
  output logic       tick_o
);
  import ctm_pkg::*;

  logic [HI_SH-1:0] pre_q;
  logic [LS_SH-1:0] ls_q;
  logic hit_hi, hit_mid, hit_lo, hit_ls, hit_slow;
  src_sel_e sel_e;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      pre_q <= '0;
      ls_q  <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (ls_tick_i) ls_q <= ls_q + 1'b1;
    end
  end

  assign hit_hi  = &pre_q[HI_SH-1:0];
  assign hit_mid = &pre_q[MID_SH-1:0];
  assign hit_lo  = &pre_q[LO_SH-1:0];
  assign hit_ls  = ls_tick_i && (&ls_q);

  generate
    if (LS_SH > 0) begin : g_lspd
      assign hit_slow = lspd_i ? hit_ls : hit_hi;
    end else begin : g_nolspd
      assign hit_slow = hit_hi;
    end
  endgenerate

  assign sel_e = src_sel_e'(sel_i);

  always_comb begin
    tick_o = 1'b0;
    if (run_i) begin
      case (sel_e)
        SRC_SLOW:  tick_o = hit_slow;
        SRC_MID:   tick_o = hit_mid;
        SRC_FAST,
        SRC_FAST2: tick_o = hit_lo;
        default:   tick_o = 1'b0;
      endcase
    end
  end

  // R2: no two enable pulses in a row
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R7: a stopped timer produces no enable pulse
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tick_o);
endmodule

// File: rtl/ctm_counter.sv
module ctm_counter (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          cap_req_i,
  input  ctm_pkg::cnt_t cmp_i,
  output ctm_pkg::cnt_t cnt_o,
  output ctm_pkg::cnt_t cap_o,
  output logic          irq_o
);
  import ctm_pkg::*;

  cnt_t cnt_q, cap_q;
  logic irq_q;
  logic match_w;

  assign match_w = tick_i && hits_compare(cnt_q, cmp_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= match_w;
      if (start_i)      cnt_q <= '0;
      else if (match_w) cnt_q <= '0;
      else if (tick_i)  cnt_q <= step_count(cnt_q);
      if (cap_req_i) cap_q <= cnt_q;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign irq_o = irq_q;

  // R3
  irq_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_q == '0));
  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !match_w && !start_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req_i |=> (cap_q == $past(cnt_q)));
  // R7
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0 && !irq_o));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned HI_SH  = 11,
  parameter int unsigned MID_SH = 7,
  parameter int unsigned LO_SH  = 3,
  parameter int unsigned LS_SH  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        ls_tick,
  output logic [15:0] cap_rdata,
  output logic        irq
);
  import ctm_pkg::*;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMP  = 2'd1;

  logic       run_q, lspd_q;
  logic [1:0] sel_q;
  cnt_t       cmp_q, cnt_w, cap_w;
  logic       ctrl_wr, cmp_wr, start_w, cap_req_w, tick_w;

  assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
  assign cmp_wr    = bus_wr && (bus_addr == A_CMP);
  assign start_w   = ctrl_wr && bus_wdata[CB_RUN] && !run_q;
  assign cap_req_w = ctrl_wr && bus_wdata[CB_CAP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      lspd_q <= 1'b0;
      sel_q  <= 2'd0;
      cmp_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q  <= bus_wdata[CB_RUN];
        lspd_q <= bus_wdata[CB_LSPD];
        sel_q  <= bus_wdata[CB_SEL_LO +: 2];
      end
      if (cmp_wr) cmp_q <= bus_wdata;
    end
  end

  ctm_prescaler #(
    .HI_SH (HI_SH),
    .MID_SH(MID_SH),
    .LO_SH (LO_SH),
    .LS_SH (LS_SH)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_q),
    .sel_i    (sel_q),
    .lspd_i   (lspd_q),
    .ls_tick_i(ls_tick),
    .tick_o   (tick_w)
  );

  ctm_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_w),
    .start_i  (start_w),
    .cap_req_i(cap_req_w),
    .cmp_i    (cmp_q),
    .cnt_o    (cnt_w),
    .cap_o    (cap_w),
    .irq_o    (irq)
  );

  assign cap_rdata = cap_w;

  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_w) |=> $stable(cnt_w));
  // R8
  cmp_write_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !run_q && !start_w) |=> (cnt_w == $past(cnt_w)));
  // R5
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_req_w |=> $stable(cap_w));
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HI  = 11;
  localparam int MID = 7;
  localparam int LO  = 1;
  localparam int LS  = 3;
  localparam int P_HI  = 1 << HI;
  localparam int P_MID = 1 << MID;
  localparam int P_LO  = 1 << LO;
  localparam int WATCHDOG = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic        ls_tick = 1'b0;
  logic [15:0] cap_rdata;
  logic        irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  cmp_timer #(.HI_SH(HI), .MID_SH(MID), .LO_SH(LO), .LS_SH(LS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ls_tick(ls_tick), .cap_rdata(cap_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected interrupt cycle
  task automatic expect_irq(input int at, input string req);
    exp_q.push_back(at);
    tag_q.push_back(req);
  endtask

  // Monitor: every interrupt pulse is matched against the queue
  always @(negedge clk) begin
    if (rst_n && irq) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected irq actual=%0d expected=none", cyc);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL %s irq cycle actual=%0d expected=%0d", t, cyc, e);
        end
      end
    end
  end

  // Caller is at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic finish_run();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 missing irq actual=%0d expected=0 pending", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 capture", cap_rdata, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 irq idle", irq, 0);

    // R3 periodic match, fast tap, compare 5
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0012);
    c0 = cyc;
    expect_irq(c0 + 5*P_LO, "R3");
    expect_irq(c0 + 10*P_LO, "R3");
    expect_irq(c0 + 15*P_LO, "R3");
    wait_to(c0 + 31);
    wr(2'd0, 16'h0002);        // stop lands at c0+32, count becomes 1
    repeat (20) @(negedge clk);
    wr(2'd0, 16'h0042);        // capture while stopped
    check("R7 hold while stopped", cap_rdata, 1);
    repeat (10) @(negedge clk);
    wr(2'd0, 16'h0042);
    check("R7 still held", cap_rdata, 1);

    // R5 capture during run, R7 no restart, R6 capture on clear edge
    wr(2'd0, 16'h0012);
    c0 = cyc;
    expect_irq(c0 + 10, "R7 no restart");
    expect_irq(c0 + 20, "R6");
    wait_to(c0 + 6);
    wr(2'd0, 16'h0052);        // lands at c0+7, count 3
    check("R5 capture", cap_rdata, 3);
    wr(2'd0, 16'h0012);        // run already set, no capture bit
    check("R5 self clear", cap_rdata, 3);
    wait_to(c0 + 19);
    wr(2'd0, 16'h0052);        // lands with the clear at c0+20
    check("R6 pre-clear count", cap_rdata, 4);
    wr(2'd0, 16'h0002);
    repeat (4) @(negedge clk);

    // R8 compare write takes effect immediately
    wr(2'd1, 16'd100);
    wr(2'd0, 16'h0012);
    c0 = cyc;
    expect_irq(c0 + 6*P_LO, "R8");
    expect_irq(c0 + 12*P_LO, "R8");
    wait_to(c0 + 7);
    wr(2'd1, 16'd6);           // lands at c0+8, count 4
    wait_to(c0 + 25);
    wr(2'd0, 16'h0002);
    repeat (4) @(negedge clk);

    // R2 middle tap
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0011);
    c0 = cyc;
    expect_irq(c0 + 2*P_MID, "R2 mid tap");
    wait_to(c0 + 2*P_MID + 3);
    wr(2'd0, 16'h0001);
    repeat (4) @(negedge clk);

    // R2 slowest tap
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h0010);
    c0 = cyc;
    expect_irq(c0 + P_HI, "R2 slow tap");
    wait_to(c0 + P_HI + 3);
    wr(2'd0, 16'h0000);
    repeat (4) @(negedge clk);

    // R9 low-speed substitution: compare 2 needs 2*8 pulses
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0030);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2*(1 << LS); i++) begin
      ls_tick = 1'b1;
      if (i == 2*(1 << LS) - 1) expect_irq(cyc + 1, "R9");
      @(negedge clk);
      ls_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (300) @(negedge clk);   // main clock alone must not fire
    wr(2'd0, 16'h0020);
    repeat (4) @(negedge clk);

    // R4 compare 0 wraps after 65536 pulses
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0012);
    c0 = cyc;
    expect_irq(c0 + 65536*P_LO, "R4");
    wait_to(c0 + 65536*P_LO + 3);
    wr(2'd0, 16'h0042);
    check("R4 count after wrap", cap_rdata, 1);

    done = 1'b1;
    finish_run();
  end
endmodule